// File: doc/BRIEF.md
# Routing Multiplexer Selection Decoder

This block looks at the configuration bits that program one routing multiplexer and reports which source that multiplexer forwards to its single sink. The bits do not map one-to-one onto switches. Each candidate source is identified by a ternary pattern over the whole group: a care mask says which bits matter, and a value says what each of those bits must be. Several sources share some of their bits, and every bit outside a source's care mask is ignored for that source.

All patterns are compared with the captured bits at the same time. The block produces a per-source hit vector, the binary index of the selected source, a valid flag, and an ambiguity flag. The pattern table is a parameter of up to 32 entries of up to 16 bits each. An optional output register, loaded under a clock enable, holds the result. Capturing the bits from a configuration stream and building the pattern table are handled elsewhere.

Top module: `routing_sel_decoder`

## Requirements
- R1: A source matches when every bit set in its care mask equals the corresponding bit of its value. Bits outside the care mask have no effect on that source, including value bits that lie outside the mask.
- R2: `hit_vec[i]` is 1 exactly when source i matches.
- R3: When exactly one source matches, `src_valid` is 1, `multi_err` is 0 and `src_idx` is that source's binary index.
- R4: When no source matches, for example an unused all-zero group, `hit_vec`, `src_idx`, `src_valid` and `multi_err` are all 0.
- R5: When two or more sources match, `multi_err` is 1, `src_valid` is 0 and `src_idx` is the lowest matching index.
- R6: With `REG_OUT`=1, the outputs take the result for `cfg_bits` at a rising clock edge where `cfg_en` is 1. They keep their value at edges where `cfg_en` is 0. A new input therefore shows one edge later.
- R7: While `rst_n` is low, and for two clock edges after it rises, all outputs are 0.
- R8: `cfg_bits[N_BITS-1]` is the leftmost bit of a written pattern. The default table has 10 bits and 8 sources, given as (care, value) in hex. In index order: 0:(02B,02B), 1:(01B,01B), 2:(20F,207), 3:(10F,107), 4:(08F,087), 5:(04F,047), 6:(02F,027), 7:(01F,017). Sources 2 to 7 each require bit 3 to be 0 and bits 2..0 to be 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Clock enable that loads a new result |
| cfg_bits | input | N_BITS | Configuration bits of one routing group |
| hit_vec | output | N_SRC | One bit per source that matches |
| src_idx | output | IDX_W | Binary index of the selected (lowest) match |
| src_valid | output | 1 | Exactly one source matches |
| multi_err | output | 1 | More than one source matches |

## Verification
Every source's exact value pattern is applied on its own. This shows that each one produces a single hit at its own index and that sources sharing bits do not trip each other. A pattern whose don't-care bits are all set shows that those bits are ignored. The all-zero group, the bits common to all sources alone, and a pattern with one cared-for bit flipped each produce the no-match result. Overlapping patterns, including all-ones, make two sources match, which exposes the choice of the lowest index and the error flag. Changing the input while the enable is low, and sampling just before the loading edge, separate the hold and latency behaviour from the decode itself.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int unsigned MAX_SRC  = 32;
  localparam int unsigned MAX_BITS = 16;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsd_match_cell.sv
module rsd_match_cell #(
  parameter int unsigned     N_BITS = 10,
  parameter logic [N_BITS-1:0] CARE  = '0,
  parameter logic [N_BITS-1:0] VALUE = '0
) (
  input  logic [N_BITS-1:0] bits_i,
  output logic              hit_o
);
  logic [N_BITS-1:0] diff;

  always_comb begin
    diff  = (bits_i ^ VALUE) & CARE;
    hit_o = (diff == '0);
  end
endmodule

// File: rtl/rsd_prio_enc.sv
module rsd_prio_enc #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N_SRC-1:0] hit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  logic [N_SRC-1:0] rest;

  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
    any_o   = |hit_i;
    rest    = hit_i & (hit_i - N_SRC'(1));
    multi_o = |rest;
  end
endmodule

// File: rtl/rsd_rst_sync.sv
module rsd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rsd_out_stage.sv
module rsd_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] q;
    logic [W-1:0] d;

    always_comb d = en ? d_i : q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign q_o = q;
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk ^ rst_n ^ en;
    assign q_o = d_i;
  end
endmodule

// File: rtl/routing_sel_decoder.sv
module routing_sel_decoder #(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned N_BITS  = 10,
  parameter bit          REG_OUT = 1'b1,
  parameter logic [N_SRC-1:0][N_BITS-1:0] PAT_CARE = {
    10'h01F, 10'h02F, 10'h04F, 10'h08F, 10'h10F, 10'h20F, 10'h01B, 10'h02B},
  parameter logic [N_SRC-1:0][N_BITS-1:0] PAT_VALUE = {
    10'h017, 10'h027, 10'h047, 10'h087, 10'h107, 10'h207, 10'h01B, 10'h02B},
  localparam int unsigned IDX_W = rsd_pkg::idx_width(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [N_BITS-1:0] cfg_bits,
  output logic [N_SRC-1:0]  hit_vec,
  output logic [IDX_W-1:0]  src_idx,
  output logic              src_valid,
  output logic              multi_err
);
  localparam int unsigned OUT_W = N_SRC + IDX_W + 2;

  logic [N_SRC-1:0] hit_raw;
  logic [IDX_W-1:0] idx_raw;
  logic             any_raw;
  logic             multi_raw;
  logic             valid_raw;
  logic             rst_n_sync;
  logic [OUT_W-1:0] res_d;
  logic [OUT_W-1:0] res_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cell
    rsd_match_cell #(
      .N_BITS(N_BITS),
      .CARE  (PAT_CARE[g]),
      .VALUE (PAT_VALUE[g])
    ) u_cell (
      .bits_i(cfg_bits),
      .hit_o (hit_raw[g])
    );
  end

  rsd_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_enc (
    .hit_i  (hit_raw),
    .idx_o  (idx_raw),
    .any_o  (any_raw),
    .multi_o(multi_raw)
  );

  always_comb begin
    valid_raw = any_raw & ~multi_raw;
    res_d     = {hit_raw, idx_raw, valid_raw, multi_raw};
  end

  rsd_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  rsd_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .en   (cfg_en),
    .d_i  (res_d),
    .q_o  (res_q)
  );

  assign {hit_vec, src_idx, src_valid, multi_err} = res_q;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned N_BITS  = 10,
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned IDX_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [N_BITS-1:0] cfg_bits,
  input logic [N_SRC-1:0]  hit_vec,
  input logic [IDX_W-1:0]  src_idx,
  input logic              src_valid,
  input logic              multi_err
);
  logic [N_SRC-1:0] below;
  logic             unused_bits;

  always_comb begin
    below       = (N_SRC'(1) << src_idx) - N_SRC'(1);
    unused_bits = ^cfg_bits;
  end

  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> ($countones(hit_vec) == 1) && hit_vec[src_idx]);

  p_valid_not_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_valid && multi_err));

  p_err_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    multi_err |-> ($countones(hit_vec) >= 2) && hit_vec[src_idx] && ((hit_vec & below) == '0));

  p_none_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> (!src_valid && !multi_err && (src_idx == '0)));

  p_hit_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> (src_valid || multi_err));

  if (REG_OUT) begin : g_hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> ($stable(hit_vec) && $stable(src_idx) && $stable(src_valid) && $stable(multi_err)));
  end
endmodule

bind routing_sel_decoder rsd_checker #(
  .N_SRC  (N_SRC),
  .N_BITS (N_BITS),
  .REG_OUT(REG_OUT),
  .IDX_W  (IDX_W)
) u_rsd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_bits (cfg_bits),
  .hit_vec  (hit_vec),
  .src_idx  (src_idx),
  .src_valid(src_valid),
  .multi_err(multi_err)
);

// File: tb/tb_routing_sel_decoder.sv
`timescale 1ns/1ps
module tb_routing_sel_decoder;
  localparam int NS = 8;
  localparam int NB = 10;
  localparam int IW = 3;

  logic          clk;
  logic          rst_n;
  logic          cfg_en;
  logic [NB-1:0] cfg_bits;
  logic [NS-1:0] hit_vec;
  logic [IW-1:0] src_idx;
  logic          src_valid;
  logic          multi_err;

  int  checks;
  int  errors;
  bit  done;

  // Value half of the default table from R8, index 0 first
  logic [NB-1:0] vals [NS];

  routing_sel_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bits(cfg_bits),
    .hit_vec(hit_vec), .src_idx(src_idx), .src_valid(src_valid), .multi_err(multi_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic expect_out(input logic [NS-1:0] h, input logic [IW-1:0] ix,
                            input logic v, input logic e, input string req);
    checks++;
    if (hit_vec !== h || src_idx !== ix || src_valid !== v || multi_err !== e) begin
      errors++;
      $display("FAIL %s: got hit=%h idx=%0d valid=%b err=%b, expected hit=%h idx=%0d valid=%b err=%b",
               req, hit_vec, src_idx, src_valid, multi_err, h, ix, v, e);
    end
  endtask

  task automatic apply(input logic [NB-1:0] b);
    @(negedge clk);
    cfg_en   = 1'b1;
    cfg_bits = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_en = 1'b1; cfg_bits = 10'h107;
    repeat (3) @(posedge clk);
    #1 expect_out('0, '0, 1'b0, 1'b0, "R7 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 expect_out('0, '0, 1'b0, 1'b0, "R7 sync release");
    repeat (3) @(posedge clk);
    #1 expect_out(8'h08, 3'd3, 1'b1, 1'b0, "R7 after release");
  endtask

  task automatic t_each_source();
    for (int i = 0; i < NS; i++) begin
      apply(vals[i]);
      expect_out(NS'(1) << i, IW'(i), 1'b1, 1'b0, "R3 R8 exact pattern");
    end
  endtask

  task automatic t_dont_care();
    apply(10'h3EF);
    expect_out(8'h01, 3'd0, 1'b1, 1'b0, "R1 dont-care bits set");
    apply(10'h017);
    expect_out(8'h80, 3'd7, 1'b1, 1'b0, "R2 highest source");
  endtask

  task automatic t_none();
    apply(10'h000);
    expect_out('0, '0, 1'b0, 1'b0, "R4 all-zero group");
    apply(10'h007);
    expect_out('0, '0, 1'b0, 1'b0, "R4 common bits only");
    apply(10'h105);
    expect_out('0, '0, 1'b0, 1'b0, "R1 one cared bit flipped");
  endtask

  task automatic t_ambiguous();
    apply(10'h03B);
    expect_out(8'h03, 3'd0, 1'b0, 1'b1, "R5 sources 0 and 1");
    apply(10'h187);
    expect_out(8'h18, 3'd3, 1'b0, 1'b1, "R5 sources 3 and 4");
    apply(10'h3FF);
    expect_out(8'h03, 3'd0, 1'b0, 1'b1, "R5 all ones");
  endtask

  task automatic t_hold_latency();
    apply(10'h047);
    expect_out(8'h20, 3'd5, 1'b1, 1'b0, "R6 load");
    @(negedge clk) cfg_en = 1'b0; cfg_bits = 10'h017;
    repeat (2) @(posedge clk);
    #1 expect_out(8'h20, 3'd5, 1'b1, 1'b0, "R6 hold with enable low");
    @(negedge clk) cfg_en = 1'b1;
    #1 expect_out(8'h20, 3'd5, 1'b1, 1'b0, "R6 before loading edge");
    @(posedge clk); #1 expect_out(8'h80, 3'd7, 1'b1, 1'b0, "R6 after loading edge");
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    vals[0] = 10'h02B; vals[1] = 10'h01B; vals[2] = 10'h207; vals[3] = 10'h107;
    vals[4] = 10'h087; vals[5] = 10'h047; vals[6] = 10'h027; vals[7] = 10'h017;
    t_reset();
    t_each_source();
    t_dont_care();
    t_none();
    t_ambiguous();
    t_hold_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule